// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Grant Control

This block keeps the return addresses of a small processor core. A subroutine call pushes the current program counter onto a six-entry hardware stack. A return pops the stack, and the most recent unreturned address is always visible on `pc_o`. The storage is a ring of six slots with a write pointer and a depth count. When a call arrives with all six slots in use, the oldest address is overwritten, so only the six most recent addresses survive. Neither the slots nor the pointer are reachable by software.

The block also decides when an interrupt may be taken. A request pulse is remembered as pending. An acknowledge pulse is issued only when the interrupt is enabled, the stack has a free level, and the core is not pushing or popping in that same cycle. The acknowledge itself pushes `pc_i`, so an interrupt never overflows the stack. While the stack is full, the request stays pending and is granted once a return frees a level.

The grant logic is a three-state machine:
- `ST_IDLE`: nothing pending.
- `ST_PEND`: a request waits for enable and a free cycle.
- `ST_HOLD`: a request waits because the stack is full.

The transitions are:
- IDLE→PEND on a request while not full.
- IDLE→HOLD on a request while full.
- PEND→IDLE on acknowledge.
- PEND→PEND on acknowledge coinciding with a new request.
- PEND→HOLD when the stack fills.
- HOLD→PEND when the stack leaves full.

Top module: `ret_stack`

## Requirements
- R1: The stack holds up to 6 return addresses of 12 bits; `full_o` is 1 exactly when 6 entries are held.
- R2: A push stores `pc_i`. `pc_o` always shows the most recently pushed entry that has not been popped, and each pop exposes the entry pushed before it (last in, first out).
- R3: A push while full discards the oldest entry, keeps the depth at 6, and leaves the 6 most recent addresses poppable in reverse order.
- R4: A pop while empty leaves the stack empty, keeps `full_o` at 0 and leaves `pc_o` unchanged.
- R5: After reset the stack is empty, `full_o` is 0, `irq_ack_o` is 0 and `pc_o` is 0.
- R6: A one-cycle `irq_req_i` pulse is remembered. While `irq_en_i` is 0 no acknowledge is given and the request stays pending. Once enabled, it is acknowledged.
- R7: While `full_o` is 1 no acknowledge is given. A pending request is acknowledged within two cycles after a pop makes the stack not full.
- R8: `irq_ack_o` is a one-cycle pulse per request. The value of `pc_i` in the acknowledge cycle is pushed and appears on `pc_o` in the next cycle.
- R9: `irq_ack_o` is never 1 in a cycle in which `push_i` or `pop_i` is 1.
- R10: When `push_i` and `pop_i` are both 1, the push is performed and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Call strobe: push `pc_i` |
| pop_i | input | 1 | Return strobe: pop the top entry |
| pc_i | input | 12 | Address to save on a call or acknowledge |
| pc_o | output | 12 | Current top-of-stack address |
| irq_req_i | input | 1 | Interrupt request pulse |
| irq_en_i | input | 1 | Interrupt enable |
| irq_ack_o | output | 1 | Interrupt acknowledge pulse |
| full_o | output | 1 | All six levels in use |

## Verification
The stack is exercised with several patterns, and each distinguishes a different fault:
- A short push/pop sequence separates correct ordering from a queue or a stale pointer.
- Seven pushes followed by six pops show whether wrap-around drops the oldest entry rather than the newest.
- Extra pops on an empty stack show whether the depth or the pointer underflows.

The interrupt path is also tried in several ways:
- A request with enable low, then raised, shows whether pending state survives.
- A request while full, followed by a pop, separates deferral from overflow or a lost request.
- A request during active pushes shows whether the grant waits for a free cycle.
- A simultaneous push and pop exposes the tie-break.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
    localparam int unsigned PC_W   = 12;
    localparam int unsigned LEVELS = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_HOLD = 2'd2
    } grant_state_t;
endpackage

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int unsigned W      = 12,
    parameter int unsigned LEVELS = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int unsigned PW = $clog2(LEVELS);
    localparam int unsigned DW = $clog2(LEVELS + 1);
    localparam logic [PW-1:0] LAST = PW'(LEVELS - 1);
    localparam logic [DW-1:0] MAXD = DW'(LEVELS);

    logic [W-1:0]  slot [LEVELS];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] top_idx;
    logic [PW-1:0] nxt_ptr;
    logic [DW-1:0] depth;
    logic          do_pop;

    assign top_idx = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
    assign nxt_ptr = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    // Push wins a tie; a pop on an empty stack does nothing (R4, R10)
    assign do_pop  = pop && !push && (depth != '0);
    assign full    = (depth == MAXD);
    assign empty   = (depth == '0);
    assign dout    = slot[top_idx];

    for (genvar i = 0; i < LEVELS; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (push && (wr_ptr == PW'(i)))
                slot[i] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            depth  <= '0;
        end else if (push) begin
            wr_ptr <= nxt_ptr;
            if (!full)
                depth <= depth + 1'b1;
        end else if (do_pop) begin
            wr_ptr <= top_idx;
            depth  <= depth - 1'b1;
        end
    end

    assert_depth_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= MAXD);
    assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> dout == $past(din));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> full);
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (empty && $stable(dout)));
endmodule

// File: rtl/rstk_irq_gate.sv
module rstk_irq_gate
    import rstk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic en,
    input  logic full,
    input  logic busy,
    output logic ack
);
    grant_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = full ? ST_HOLD : ST_PEND;
            ST_PEND: begin
                if (ack)       state_d = req ? ST_PEND : ST_IDLE;
                else if (full) state_d = ST_HOLD;
            end
            ST_HOLD: if (!full) state_d = ST_PEND;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ack = (state_q == ST_PEND) && en && !full && !busy;
    end

    assert_ack_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !full);
    assert_ack_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !busy);
    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req) |=> !ack);
    assert_disabled_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !ack);
endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import rstk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] pc_o,
    input  logic            irq_req_i,
    input  logic            irq_en_i,
    output logic            irq_ack_o,
    output logic            full_o
);
    logic ack;
    logic busy;
    logic st_push;
    logic st_empty;

    assign busy      = push_i | pop_i;
    assign st_push   = push_i | ack;
    assign irq_ack_o = ack;

    rstk_store #(.W(PC_W), .LEVELS(LEVELS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (st_push),
        .pop   (pop_i),
        .din   (pc_i),
        .dout  (pc_o),
        .full  (full_o),
        .empty (st_empty)
    );

    rstk_irq_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_req_i),
        .en    (irq_en_i),
        .full  (full_o),
        .busy  (busy),
        .ack   (ack)
    );

    assert_full_not_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && st_empty));
    assert_ack_pushes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |=> pc_o == $past(pc_i));
endmodule

// File: tb/ret_stack_tb.sv
module ret_stack_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [11:0] pc_i = '0;
    logic [11:0] pc_o;
    logic        irq_req_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic        irq_ack_o;
    logic        full_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ret_stack u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .pc_i(pc_i),
        .pc_o(pc_o), .irq_req_i(irq_req_i), .irq_en_i(irq_en_i),
        .irq_ack_o(irq_ack_o), .full_o(full_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_push(input logic [11:0] v);
        @(negedge clk); push_i = 1'b1; pc_i = v;
        @(negedge clk); push_i = 1'b0;
    endtask

    task automatic pop_expect(input logic [11:0] v, input string tag);
        @(negedge clk);
        chk(pc_o == v, tag, pc_o, v);
        pop_i = 1'b1;
        @(negedge clk); pop_i = 1'b0;
    endtask

    task automatic flush();
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); pop_i = 1'b1;
        end
        @(negedge clk); pop_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(full_o == 1'b0, "R5 full", full_o, 0);
        chk(irq_ack_o == 1'b0, "R5 ack", irq_ack_o, 0);
        chk(pc_o == 12'h000, "R5 pc", pc_o, 0);
    endtask

    task automatic t_lifo();
        do_push(12'hA01); do_push(12'hA02); do_push(12'hA03);
        chk(full_o == 1'b0, "R1 not full at 3", full_o, 0);
        pop_expect(12'hA03, "R2 pop1");
        pop_expect(12'hA02, "R2 pop2");
        do_push(12'hA04);
        pop_expect(12'hA04, "R2 pop3");
        pop_expect(12'hA01, "R2 pop4");
    endtask

    task automatic t_overflow();
        logic [11:0] top;
        for (int i = 1; i <= 6; i++) do_push(12'(12'h100 + i));
        chk(full_o == 1'b1, "R1 full at 6", full_o, 1);
        do_push(12'h107);
        chk(full_o == 1'b1, "R3 full after overflow", full_o, 1);
        for (int i = 7; i >= 2; i--) pop_expect(12'(12'h100 + i), "R3 overflow pop order");
        chk(full_o == 1'b0, "R3 empty after six pops", full_o, 0);
        @(negedge clk); top = pc_o;
        pop_i = 1'b1;
        @(negedge clk); pop_i = 1'b0;
        chk(pc_o == top, "R4 empty pop pc", pc_o, top);
        chk(full_o == 1'b0, "R4 empty pop full", full_o, 0);
        do_push(12'h0C9);
        pop_expect(12'h0C9, "R4 depth did not underflow");
        @(negedge clk);
        chk(pc_o == top, "R4 pc restored", pc_o, top);
    endtask

    task automatic t_irq_basic();
        @(negedge clk); irq_en_i = 1'b1; irq_req_i = 1'b1; pc_i = 12'h3A0;
        @(negedge clk); irq_req_i = 1'b0;
        chk(irq_ack_o == 1'b1, "R8 ack raised", irq_ack_o, 1);
        @(negedge clk);
        chk(irq_ack_o == 1'b0, "R8 ack one cycle", irq_ack_o, 0);
        chk(pc_o == 12'h3A0, "R8 ack pushed pc", pc_o, 12'h3A0);
        pop_expect(12'h3A0, "R8 pop irq frame");
    endtask

    task automatic t_irq_disabled();
        @(negedge clk); irq_en_i = 1'b0; irq_req_i = 1'b1; pc_i = 12'h455;
        @(negedge clk); irq_req_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(irq_ack_o == 1'b0, "R6 no ack while disabled", irq_ack_o, 0);
            @(negedge clk);
        end
        irq_en_i = 1'b1; #1;
        chk(irq_ack_o == 1'b1, "R6 ack after enable", irq_ack_o, 1);
        @(negedge clk);
        chk(pc_o == 12'h455, "R6 pushed pc", pc_o, 12'h455);
        pop_expect(12'h455, "R6 pop");
    endtask

    task automatic t_irq_full();
        for (int i = 0; i < 6; i++) do_push(12'(12'h210 + i));
        @(negedge clk); irq_req_i = 1'b1; pc_i = 12'h7E7;
        @(negedge clk); irq_req_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(irq_ack_o == 1'b0, "R7 held while full", irq_ack_o, 0);
            @(negedge clk);
        end
        chk(pc_o == 12'h215, "R7 no overflow push", pc_o, 12'h215);
        pop_i = 1'b1;
        @(negedge clk); pop_i = 1'b0;
        chk(full_o == 1'b0, "R7 freed level", full_o, 0);
        chk(irq_ack_o == 1'b0, "R7 hold one more cycle", irq_ack_o, 0);
        @(negedge clk);
        chk(irq_ack_o == 1'b1, "R7 granted after pop", irq_ack_o, 1);
        @(negedge clk);
        chk(pc_o == 12'h7E7, "R7 irq frame on top", pc_o, 12'h7E7);
        chk(full_o == 1'b1, "R7 full again", full_o, 1);
        pop_expect(12'h7E7, "R7 pop irq");
        pop_expect(12'h214, "R7 older frame intact");
        flush();
    endtask

    task automatic t_irq_busy();
        @(negedge clk); irq_req_i = 1'b1; push_i = 1'b1; pc_i = 12'h111;
        @(negedge clk); irq_req_i = 1'b0; pc_i = 12'h222;
        chk(irq_ack_o == 1'b0, "R9 no ack during push", irq_ack_o, 0);
        @(negedge clk); push_i = 1'b0; pop_i = 1'b1;
        #1 chk(irq_ack_o == 1'b0, "R9 no ack during pop", irq_ack_o, 0);
        @(negedge clk); pop_i = 1'b0; pc_i = 12'h333;
        #1 chk(irq_ack_o == 1'b1, "R9 ack when bus free", irq_ack_o, 1);
        @(negedge clk);
        pop_expect(12'h333, "R9 ack frame");
        pop_expect(12'h111, "R9 earlier frame");
    endtask

    task automatic t_tie();
        do_push(12'h050);
        @(negedge clk); push_i = 1'b1; pop_i = 1'b1; pc_i = 12'h060;
        @(negedge clk); push_i = 1'b0; pop_i = 1'b0;
        pop_expect(12'h060, "R10 push won");
        pop_expect(12'h050, "R10 pop ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lifo();
        flush();
        t_overflow();
        flush();
        t_irq_basic();
        t_irq_disabled();
        t_irq_full();
        t_irq_busy();
        flush();
        t_tie();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule